// File: doc/BRIEF.md
# Triple-Port Parallel I/O Register Block

This block gives a processor three 8-bit parallel ports, called A, B and C, plus one control register. All four are reached through a 2-bit address on a simple synchronous bus with a select, a write enable, write data and read data. Only basic latched operation is provided. Each port has an output latch. Each port also has an output-enable that tells the pad logic whether the block drives the pins or only samples them. Port C is split into two nibbles, and each nibble has its own direction.

Writing the control register does one of two things, chosen by bit 7. With bit 7 low, the write forces a single bit of the port C latch to 0 or 1. With bit 7 high, the write is a configuration word that sets the four directions and clears every latch. Configuration words that ask for a handshake or bidirectional mode are refused, and a sticky error flag records the refusal. Every port access also drives a one-cycle notify strobe, so that external logic can react to a port being written or read.

Top module: `pio_triport`

## Requirements
- R1: A write to address 0, 1 or 2 loads the write data into the latch of port A, B or C respectively. The latch appears on `pa_out_o`, `pb_out_o` or `pc_out_o` in the cycle after the write. The latch is loaded whatever the port's direction.
- R2: In the cycle after a write to address 0, 1 or 2, exactly one bit of `wr_stb_o` is high: bit 0 for port A, bit 1 for port B, bit 2 for port C. In any cycle that follows a cycle with no port write, `wr_stb_o` is zero.
- R3: A read of address 0, 1 or 2 places that port's value on `rdata_o` in the following cycle. The same cycle, the matching bit of `rd_stb_o` is high (bit 0 = A, bit 1 = B, bit 2 = C). `rdata_o` holds its value until the next read.
- R4: A read of a port or nibble set as input returns the pin value sampled in the read cycle. A port or nibble set as output returns its latch. For port C, bits 7:4 follow the upper-nibble direction and bits 3:0 follow the lower-nibble direction.
- R5: A control write (address 3) with bit 7 = 0 sets bit number wdata[3:1] of the port C latch to wdata[0]. The other seven bits of the latch keep their value.
- R6: A control write with bit 7 = 1, wdata[6:5] = 0 and wdata[2] = 0 is a valid configuration word. It sets the directions as follows: wdata[4]=1 makes port A an input, wdata[1]=1 makes port B an input, wdata[3]=1 makes C[7:4] an input, and wdata[0]=1 makes C[3:0] an input. Each output-enable (`pa_oe_o`, `pb_oe_o`, `pch_oe_o`, `pcl_oe_o`) is high exactly when its port or nibble is an output.
- R7: A valid configuration word clears the latches of all three ports to zero.
- R8: A control write with bit 7 = 1 and either wdata[6:5] nonzero or wdata[2] = 1 is refused. It sets `mode_err_o`, which stays high until reset, and it changes neither the directions nor the latches.
- R9: A read of address 3 returns zero on `rdata_o`, raises no strobe and changes no state.
- R10: After reset, all ports and nibbles are inputs (all output-enables low), all latches are zero, `mode_err_o` is low and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0 = port A, 1 = port B, 2 = port C, 3 = control |
| bus_wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after a read |
| pa_pin_i | input | 8 | Port A pin levels |
| pb_pin_i | input | 8 | Port B pin levels |
| pc_pin_i | input | 8 | Port C pin levels |
| pa_out_o | output | 8 | Port A latch |
| pb_out_o | output | 8 | Port B latch |
| pc_out_o | output | 8 | Port C latch |
| pa_oe_o | output | 1 | Port A drives its pins |
| pb_oe_o | output | 1 | Port B drives its pins |
| pch_oe_o | output | 1 | Port C upper nibble drives its pins |
| pcl_oe_o | output | 1 | Port C lower nibble drives its pins |
| wr_stb_o | output | 3 | One-cycle write notify, one bit per port |
| rd_stb_o | output | 3 | One-cycle read notify, one bit per port |
| mode_err_o | output | 1 | Sticky flag: a configuration word was refused |

## Verification
The assertions assume that the bus inputs are stable and known at every rising edge while `bus_sel_i` is high. They also assume that the pins are stable around the edge of a read cycle, because the pin value is captured at that edge. The bench changes every bus input and every pin only on the falling edge, and holds it for one full cycle. The bench sweeps all sixteen direction combinations, every port C bit with both values, and the refused configuration words. Because the error flag is sticky, the refused words come last.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int unsigned PORT_W  = 8;
    localparam int unsigned N_PORTS = 3;
    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned IDX_W   = $clog2(PORT_W);

    typedef enum logic [ADDR_W-1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    typedef struct packed {
        logic [PORT_W-1:0]  lat_a;
        logic [PORT_W-1:0]  lat_b;
        logic [PORT_W-1:0]  lat_c;
        logic               in_a;
        logic               in_b;
        logic               in_ch;
        logic               in_cl;
        logic [PORT_W-1:0]  rdata;
        logic [N_PORTS-1:0] wr_stb;
        logic [N_PORTS-1:0] rd_stb;
        logic               err;
    } pio_state_t;
endpackage

// File: rtl/pio_cmd_decode.sv
module pio_cmd_decode
    import pio_pkg::*;
(
    input  logic [PORT_W-1:0] word_i,
    output logic              is_bit_op_o,
    output logic [IDX_W-1:0]  bit_idx_o,
    output logic              bit_val_o,
    output logic              cfg_ok_o,
    output logic              in_a_o,
    output logic              in_b_o,
    output logic              in_ch_o,
    output logic              in_cl_o
);
    always_comb begin
        is_bit_op_o = ~word_i[7];
        bit_idx_o   = word_i[3:1];
        bit_val_o   = word_i[0];
        cfg_ok_o    = word_i[7] && (word_i[6:5] == 2'b00) && !word_i[2];
        in_a_o      = word_i[4];
        in_ch_o     = word_i[3];
        in_b_o      = word_i[1];
        in_cl_o     = word_i[0];
    end
endmodule

// File: rtl/pio_pin_view.sv
module pio_pin_view #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned SEGS  = 1
) (
    input  logic [WIDTH-1:0] latch_i,
    input  logic [WIDTH-1:0] pin_i,
    input  logic [SEGS-1:0]  seg_in_i,
    output logic [WIDTH-1:0] view_o
);
    localparam int unsigned SEG_W = WIDTH / SEGS;

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        assign view_o[s*SEG_W +: SEG_W] = seg_in_i[s] ? pin_i[s*SEG_W +: SEG_W]
                                                      : latch_i[s*SEG_W +: SEG_W];
    end

    initial begin
        a_seg_fit_chk: assert (SEG_W * SEGS == WIDTH);
    end
endmodule

// File: rtl/pio_triport.sv
module pio_triport
    import pio_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bus_sel_i,
    input  logic                bus_we_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [PORT_W-1:0]   bus_wdata_i,
    output logic [PORT_W-1:0]   rdata_o,
    input  logic [PORT_W-1:0]   pa_pin_i,
    input  logic [PORT_W-1:0]   pb_pin_i,
    input  logic [PORT_W-1:0]   pc_pin_i,
    output logic [PORT_W-1:0]   pa_out_o,
    output logic [PORT_W-1:0]   pb_out_o,
    output logic [PORT_W-1:0]   pc_out_o,
    output logic                pa_oe_o,
    output logic                pb_oe_o,
    output logic                pch_oe_o,
    output logic                pcl_oe_o,
    output logic [N_PORTS-1:0]  wr_stb_o,
    output logic [N_PORTS-1:0]  rd_stb_o,
    output logic                mode_err_o
);
    pio_state_t st_d, st_q;

    logic             is_bit_op, bit_val, cfg_ok;
    logic [IDX_W-1:0] bit_idx;
    logic             cfg_a, cfg_b, cfg_ch, cfg_cl;
    logic [PORT_W-1:0] view_a, view_b, view_c;

    pio_cmd_decode u_dec (
        .word_i      (bus_wdata_i),
        .is_bit_op_o (is_bit_op),
        .bit_idx_o   (bit_idx),
        .bit_val_o   (bit_val),
        .cfg_ok_o    (cfg_ok),
        .in_a_o      (cfg_a),
        .in_b_o      (cfg_b),
        .in_ch_o     (cfg_ch),
        .in_cl_o     (cfg_cl)
    );

    pio_pin_view #(.WIDTH(PORT_W), .SEGS(1)) u_view_a (
        .latch_i (st_q.lat_a), .pin_i (pa_pin_i), .seg_in_i (st_q.in_a), .view_o (view_a)
    );
    pio_pin_view #(.WIDTH(PORT_W), .SEGS(1)) u_view_b (
        .latch_i (st_q.lat_b), .pin_i (pb_pin_i), .seg_in_i (st_q.in_b), .view_o (view_b)
    );
    pio_pin_view #(.WIDTH(PORT_W), .SEGS(2)) u_view_c (
        .latch_i (st_q.lat_c), .pin_i (pc_pin_i),
        .seg_in_i ({st_q.in_ch, st_q.in_cl}), .view_o (view_c)
    );

    always_comb begin
        st_d        = st_q;
        st_d.wr_stb = '0;
        st_d.rd_stb = '0;
        if (bus_sel_i) begin
            if (bus_we_i) begin
                unique case (sel_e'(bus_addr_i))
                    SEL_A: begin st_d.lat_a = bus_wdata_i; st_d.wr_stb = 3'b001; end
                    SEL_B: begin st_d.lat_b = bus_wdata_i; st_d.wr_stb = 3'b010; end
                    SEL_C: begin st_d.lat_c = bus_wdata_i; st_d.wr_stb = 3'b100; end
                    SEL_CTRL: begin
                        if (is_bit_op) begin
                            st_d.lat_c[bit_idx] = bit_val;
                        end else if (cfg_ok) begin
                            st_d.in_a  = cfg_a;
                            st_d.in_b  = cfg_b;
                            st_d.in_ch = cfg_ch;
                            st_d.in_cl = cfg_cl;
                            st_d.lat_a = '0;
                            st_d.lat_b = '0;
                            st_d.lat_c = '0;
                        end else begin
                            st_d.err = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else begin
                unique case (sel_e'(bus_addr_i))
                    SEL_A:    begin st_d.rdata = view_a; st_d.rd_stb = 3'b001; end
                    SEL_B:    begin st_d.rdata = view_b; st_d.rd_stb = 3'b010; end
                    SEL_C:    begin st_d.rdata = view_c; st_d.rd_stb = 3'b100; end
                    SEL_CTRL: st_d.rdata = '0;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.in_a  <= 1'b1;
            st_q.in_b  <= 1'b1;
            st_q.in_ch <= 1'b1;
            st_q.in_cl <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o    = st_q.rdata;
    assign pa_out_o   = st_q.lat_a;
    assign pb_out_o   = st_q.lat_b;
    assign pc_out_o   = st_q.lat_c;
    assign pa_oe_o    = ~st_q.in_a;
    assign pb_oe_o    = ~st_q.in_b;
    assign pch_oe_o   = ~st_q.in_ch;
    assign pcl_oe_o   = ~st_q.in_cl;
    assign wr_stb_o   = st_q.wr_stb;
    assign rd_stb_o   = st_q.rd_stb;
    assign mode_err_o = st_q.err;

    // R2
    wr_strobe_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && bus_we_i && bus_addr_i == 2'd1) |=> (wr_stb_o == 3'b010));
    // R2
    no_stray_wr_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_sel_i && bus_we_i) |=> (wr_stb_o == 3'b000));
    // R3
    rd_strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(rd_stb_o));
    // R5
    bit_op_keeps_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && bus_we_i && bus_addr_i == 2'd3 && !bus_wdata_i[7]) |=>
        ((pc_out_o ^ $past(pc_out_o)) & ~(8'd1 << $past(bus_wdata_i[3:1]))) == 8'd0);
    // R7
    cfg_clears_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && bus_we_i && bus_addr_i == 2'd3 && bus_wdata_i[7]
         && bus_wdata_i[6:5] == 2'b00 && !bus_wdata_i[2]) |=>
        (pa_out_o == 8'd0 && pb_out_o == 8'd0 && pc_out_o == 8'd0));
    // R8
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_err_o |=> mode_err_o);
    // R8
    refused_keeps_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && bus_we_i && bus_addr_i == 2'd3 && bus_wdata_i[7]
         && (bus_wdata_i[6:5] != 2'b00 || bus_wdata_i[2])) |=>
        ($stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pch_oe_o) && $stable(pcl_oe_o)
         && mode_err_o));
    // R9
    ctrl_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && !bus_we_i && bus_addr_i == 2'd3) |=>
        (rdata_o == 8'd0 && rd_stb_o == 3'b000));
endmodule

// File: tb/pio_triport_bench.sv
module pio_triport_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, we = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] pa_pin = '0, pb_pin = '0, pc_pin = '0;
    logic [7:0] rdata, pa_out, pb_out, pc_out;
    logic       pa_oe, pb_oe, pch_oe, pcl_oe, merr;
    logic [2:0] wstb, rstb;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_lat [3];
    bit m_in [4];   // a, b, ch, cl
    bit m_err;

    always #2 clk = ~clk;

    pio_triport u_pio_triport (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .rdata_o(rdata),
        .pa_pin_i(pa_pin), .pb_pin_i(pb_pin), .pc_pin_i(pc_pin),
        .pa_out_o(pa_out), .pb_out_o(pb_out), .pc_out_o(pc_out),
        .pa_oe_o(pa_oe), .pb_oe_o(pb_oe), .pch_oe_o(pch_oe), .pcl_oe_o(pcl_oe),
        .wr_stb_o(wstb), .rd_stb_o(rstb), .mode_err_o(merr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input bit w, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    function automatic logic [7:0] exp_view(input int p);
        logic [7:0] pin;
        pin = (p == 0) ? pa_pin : (p == 1) ? pb_pin : pc_pin;
        if (p == 0) return m_in[0] ? pin : m_lat[0];
        if (p == 1) return m_in[1] ? pin : m_lat[1];
        return {m_in[2] ? pin[7:4] : m_lat[2][7:4], m_in[3] ? pin[3:0] : m_lat[2][3:0]};
    endfunction

    task automatic check_state(input string tag);
        check({tag, " R1 latA"}, pa_out, m_lat[0]);
        check({tag, " R1 latB"}, pb_out, m_lat[1]);
        check({tag, " R1 latC"}, pc_out, m_lat[2]);
        check({tag, " R6 oe"}, {pa_oe, pb_oe, pch_oe, pcl_oe},
              {!m_in[0], !m_in[1], !m_in[2], !m_in[3]});
        check({tag, " R8 err"}, merr, m_err);
    endtask

    task automatic read_port(input int p, input string tag);
        logic [7:0] e;
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = 2'(p);
        e = exp_view(p);
        @(negedge clk);
        sel = 1'b0;
        check({tag, " R3 R4 rdata"}, rdata, e);
        check({tag, " R3 rd strobe"}, rstb, 3'b001 << p);
        check({tag, " R2 no wr strobe on read"}, wstb, 3'b000);
    endtask

    task automatic cfg(input logic [3:0] m);
        logic [7:0] w;
        w = 8'h80 | {3'b000, m[3], m[2], 1'b0, m[1], m[0]};
        access(1'b1, 2'd3, w);
        m_in[0] = m[3]; m_in[2] = m[2]; m_in[1] = m[1]; m_in[3] = m[0];
        for (int i = 0; i < 3; i++) m_lat[i] = '0;
        check_state("R6 R7 cfg");
    endtask

    initial begin
        for (int i = 0; i < 3; i++) m_lat[i] = '0;
        for (int i = 0; i < 4; i++) m_in[i] = 1'b1;
        m_err = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 rdata", rdata, 8'd0);
        check("R10 strobes", {wstb, rstb}, 6'd0);
        check_state("R10 reset");
        rst_n = 1'b1;

        // R1 R2 writes with all-input directions
        for (int p = 0; p < 3; p++) begin
            for (int v = 0; v < 256; v += 37) begin
                access(1'b1, 2'(p), 8'(v + p));
                m_lat[p] = 8'(v + p);
                check("R2 wr strobe", wstb, 3'b001 << p);
                check("R2 R3 no rd strobe", rstb, 3'b000);
                check_state("R1 write");
            end
        end
        @(negedge clk);
        check("R2 idle strobe", {wstb, rstb}, 6'd0);

        // R3 R4 inputs read pins
        for (int v = 0; v < 256; v += 51) begin
            pa_pin = 8'(v); pb_pin = 8'(v) ^ 8'h5A; pc_pin = ~8'(v);
            for (int p = 0; p < 3; p++) read_port(p, "in");
        end

        // R6 R7 R4 sweep of all direction words
        for (int m = 0; m < 16; m++) begin
            cfg(4'(m));
            for (int p = 0; p < 3; p++) begin
                access(1'b1, 2'(p), 8'(8'h3C + m * 11 + p * 70));
                m_lat[p] = 8'(8'h3C + m * 11 + p * 70);
            end
            pa_pin = 8'(m * 17); pb_pin = 8'(8'hC3 ^ m); pc_pin = 8'(8'h96 + m);
            for (int p = 0; p < 3; p++) read_port(p, "dir sweep");
            check_state("R1 after dir sweep");
        end

        // R5 bit set/reset, all bits and values
        cfg(4'b0000);
        for (int b = 0; b < 8; b++) begin
            for (int v = 0; v < 2; v++) begin
                access(1'b1, 2'd2, (v == 1) ? 8'h00 : 8'hFF);
                m_lat[2] = (v == 1) ? 8'h00 : 8'hFF;
                access(1'b1, 2'd3, {4'b0000, 3'(b), 1'(v)});
                m_lat[2][b] = 1'(v);
                check("R5 bit op latC", pc_out, m_lat[2]);
                check("R5 bit op no strobe", wstb, 3'b000);
            end
        end
        access(1'b1, 2'd2, 8'hA5); m_lat[2] = 8'hA5;
        access(1'b1, 2'd3, 8'h0F); m_lat[2][7] = 1'b1;
        access(1'b1, 2'd3, 8'h00); m_lat[2][0] = 1'b0;
        check("R5 bit op sequence", pc_out, 8'hA4);

        // R9 control read
        access(1'b1, 2'd0, 8'h77); m_lat[0] = 8'h77;
        read_port(0, "pre ctrl read");
        access(1'b0, 2'd3, 8'h00);
        check("R9 ctrl read data", rdata, 8'd0);
        check("R9 ctrl read strobes", {wstb, rstb}, 6'd0);
        check_state("R9 ctrl read state");

        // R8 refused configuration words (sticky, so last)
        cfg(4'b0101);
        access(1'b1, 2'd0, 8'h11); m_lat[0] = 8'h11;
        access(1'b1, 2'd2, 8'h22); m_lat[2] = 8'h22;
        check_state("R8 before refusal");
        foreach (m_in[i]) ;
        begin
            logic [7:0] bad [4];
            bad[0] = 8'hA0; bad[1] = 8'hC0; bad[2] = 8'h84; bad[3] = 8'hFF;
            for (int k = 0; k < 4; k++) begin
                access(1'b1, 2'd3, bad[k]);
                m_err = 1;
                check_state("R8 refused word");
            end
        end
        cfg(4'b1010);
        check("R8 err stays after valid word", merr, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule